// File: doc/BRIEF.md
# PWM Dead-Band Generator with Shadowed Delays

This block sits between a PWM action qualifier and the output pins of a half-bridge. It takes the two raw action-qualifier waveforms and forms from them a pair of outputs with programmable dead time. A rising-edge delay unit holds back the turn-on edge of its input. A falling-edge delay unit holds back the turn-off edge of its input. Both delays are counted in time-base clocks. A control word selects the input feeding each delay unit, inverts either output, and chooses how the delayed signals are routed to the outputs. A phase-shift mode derives output B from input A, shifted in time.

Software reaches the block through a small write port with four registers. The rising delay, the falling delay and the control word each have a shadow copy. A shadow copy moves into its active register on a selectable time-base counter event, or together with the other global-mode registers on a global load strobe. The block flags delay values that cannot work with the chosen global load event.

Top module: `pwm_deadband`

## Requirements
- R1: After reset, both outputs and the configuration-error flag are 0, both active delays are 0, the control word is 0 and every register is written directly to its active copy.
- R2: Every output passes through exactly one register stage. With zero delays, or in bypass routing (route 3), each output equals its selected input one clock later.
- R3: In split routing (route 0, the reset routing), output A carries the rising-delayed signal, which rises d_rise clocks later than the one-clock pipeline would give and falls with the pipeline only. Output B carries the falling-delayed signal, which falls d_fall clocks late and rises with the pipeline only.
- R4: An input pulse that lasts no longer than the programmed rising delay produces no pulse on the rising-delayed output.
- R5: Route 1 applies the rising delay and then the falling delay to output A, and passes raw input B to output B. Route 2 applies both delays to output B and passes raw input A to output A. The two delays are never applied to both outputs at once.
- R6: In phase mode (control bit 6), output A is input A and output B is input A with both edges delayed by the rising delay. If the A pulse is not longer than that shift, B stays low for that pulse.
- R7: Control bit 2 inverts output A and control bit 3 inverts output B.
- R8: Control bit 0 selects the source of the rising-delay unit and bit 1 selects the source of the falling-delay unit (0 = input A, 1 = input B).
- R9: The address map is 0 = rising delay, 1 = falling delay, 2 = control word, 3 = load configuration. The load configuration holds these fields: rising load mode in bits 1:0, falling load mode in 3:2, control load mode in 5:4, global event in 7:6, shadow enables in bits 8 (rising), 9 (falling) and 10 (control), and global selects in bits 11, 12 and 13. The load-mode code is 00 = counter zero, 01 = counter period, 10 = either, 11 = frozen. With shadowing enabled, a write reaches the active register only on the selected event.
- R10: A register set to global mode ignores its own counter events. It loads only when the global strobe coincides with the counter event given by the global event field.
- R11: A change of an active delay while an edge is being delayed does not change that edge. The new value applies from the next input edge.
- R12: One clock after the active values change, the error flag is 1 when a global-mode delay is 0 and the global event includes counter zero, or when it equals the period input and the global event includes counter period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| aq_a_i | input | 1 | Raw action-qualifier waveform A |
| aq_b_i | input | 1 | Raw action-qualifier waveform B |
| ev_zero_i | input | 1 | Strobe: time-base counter equals zero |
| ev_prd_i | input | 1 | Strobe: time-base counter equals period |
| ev_glb_i | input | 1 | Global load strobe |
| prd_i | input | CNT_W | Current period value, used for the error check |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | DATA_W | Register write data |
| pwm_a_o | output | 1 | Dead-band output A |
| pwm_b_o | output | 1 | Dead-band output B |
| cfg_err_o | output | 1 | Delay value invalid for the chosen global load event |

## Verification
The bench builds the block with the default CNT_W of 12. DATA_W therefore resolves to 14, so a single write can reach every field of the load configuration. Delays of 0 to 7 clocks are used, which fit inside a 16-step window and leave room to see swallowed pulses, the full chained dead band and the phase shift end to end. Period values in the same small range make the delay-equals-period error case easy to reach.

// File: rtl/db_pkg.sv
`timescale 1ns/1ps
// Shared types for the dead-band generator.
// Assumes: field positions below are the software-visible register layout.
package db_pkg;

    typedef enum logic [1:0] {
        LD_ZERO   = 2'b00,
        LD_PRD    = 2'b01,
        LD_EITHER = 2'b10,
        LD_FROZEN = 2'b11
    } load_mode_e;

    typedef enum logic [1:0] {
        RT_SPLIT  = 2'b00,
        RT_BOTH_A = 2'b01,
        RT_BOTH_B = 2'b10,
        RT_BYPASS = 2'b11
    } route_e;

    // control word, bit 6 down to bit 0
    typedef struct packed {
        logic   phase;
        route_e route;
        logic   pol_b;
        logic   pol_a;
        logic   src_fall;
        logic   src_rise;
    } ctrl_t;

    // load configuration, bit 13 down to bit 0
    typedef struct packed {
        logic       ctl_glb;
        logic       fall_glb;
        logic       rise_glb;
        logic       ctl_sh;
        logic       fall_sh;
        logic       rise_sh;
        load_mode_e glb_lm;
        load_mode_e ctl_lm;
        load_mode_e fall_lm;
        load_mode_e rise_lm;
    } loadcfg_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int LC_W   = $bits(loadcfg_t);

    // Decode a load-mode code against the two counter event strobes.
    function automatic logic load_hit(input load_mode_e m, input logic z, input logic p);
        case (m)
            LD_ZERO:   return z;
            LD_PRD:    return p;
            LD_EITHER: return z | p;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/db_shadow_reg.sv
`timescale 1ns/1ps
// Register with an optional shadow copy.
// Shadowing off: a write lands in the active copy at once.
// Shadowing on: a write lands in the shadow copy only, and load_i copies it across.
// Assumes load_i is a single-cycle pulse that is already decoded.
module db_shadow_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         sh_en_i,
    input  logic         load_i,
    output logic [W-1:0] act_o
);

    logic [W-1:0] shadow_q;
    logic [W-1:0] act_q;

    // Capture writes into the shadow copy and move values into the active copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            act_q    <= '0;
        end else begin
            if (wr_i)
                shadow_q <= wdata_i;
            if (!sh_en_i && wr_i)
                act_q <= wdata_i;
            else if (sh_en_i && load_i)
                act_q <= shadow_q;
        end
    end

    assign act_o = act_q;

    // R9: while shadowed, the active copy moves only on a load pulse
    p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_en_i && !load_i) |=> (act_o == $past(act_o)));

    // R9: with shadowing off, a write is visible on the next cycle
    p_direct_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sh_en_i && wr_i) |=> (act_o == $past(wdata_i)));

endmodule

// File: rtl/db_edge_delay.sv
`timescale 1ns/1ps
// Single-edge delay unit.
// FALLING = 0 delays the 0->1 edge, FALLING = 1 delays the 1->0 edge.
// The opposite edge passes through with no delay.
// The output is combinational; the caller provides the output register.
// The delay is sampled when an edge arrives and held until the input
// returns, so a change of dly_i mid-edge affects only the next edge.
module db_edge_delay #(
    parameter int W       = 12,
    parameter bit FALLING = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         x_i,
    input  logic [W-1:0] dly_i,
    output logic         y_o
);

    logic         xin;
    logic         run_q;
    logic [W-1:0] cnt_q;
    logic [W-1:0] held_q;
    logic [W-1:0] d_use;
    logic         core;

    assign xin   = x_i ^ FALLING;
    assign d_use = run_q ? held_q : dly_i;
    assign core  = xin && (cnt_q >= d_use);
    assign y_o   = core ^ FALLING;

    // Count consecutive active samples, saturating at the delay in use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            cnt_q  <= '0;
            held_q <= '0;
        end else begin
            run_q <= xin;
            if (!xin) begin
                cnt_q <= '0;
            end else begin
                held_q <= d_use;
                if (cnt_q < d_use)
                    cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R3: the delayed edge appears exactly when the count reaches the delay
    p_edge_on_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core) |-> (cnt_q == d_use));

    // R4: a fresh edge with a non-zero delay never passes at once
    p_no_early_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xin && !run_q && d_use != '0) |-> !core);

    // R11: once an edge is under way its delay stays fixed
    p_delay_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && xin) |=> (!run_q || held_q == $past(held_q)));

endmodule

// File: rtl/pwm_deadband.sv
`timescale 1ns/1ps
// PWM dead-band generator.
// Forms two dead-time-adjusted outputs from raw action-qualifier waveforms.
// Features: rising and falling delay units, input select, polarity, routing
// and a phase-shift mode. Delays and control have shadow copies, loaded on
// counter events or on a global strobe.
// Assumes: the event strobes are single-cycle pulses from the time-base counter.
module pwm_deadband
    import db_pkg::*;
#(
    parameter  int CNT_W  = 12,
    localparam int DATA_W = (CNT_W > LC_W) ? CNT_W : LC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aq_a_i,
    input  logic              aq_b_i,
    input  logic              ev_zero_i,
    input  logic              ev_prd_i,
    input  logic              ev_glb_i,
    input  logic [CNT_W-1:0]  prd_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              pwm_a_o,
    output logic              pwm_b_o,
    output logic              cfg_err_o
);

    loadcfg_t          lc;
    logic              glb_hit;
    logic [1:0]        dly_sh;
    logic [1:0]        dly_ld;
    logic [CNT_W-1:0]  dly_act [2];
    logic [CTRL_W-1:0] ctl_raw;
    ctrl_t             ctl;
    logic              ctl_ld;

    // Load configuration register: written directly, never shadowed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lc <= '0;
        else if (wr_en_i && wr_addr_i == 2'd3)
            lc <= loadcfg_t'(wr_data_i[LC_W-1:0]);
    end

    assign glb_hit = ev_glb_i && load_hit(lc.glb_lm, ev_zero_i, ev_prd_i);
    assign dly_sh  = {lc.fall_sh, lc.rise_sh};
    assign dly_ld[0] = lc.rise_glb ? glb_hit : load_hit(lc.rise_lm, ev_zero_i, ev_prd_i);
    assign dly_ld[1] = lc.fall_glb ? glb_hit : load_hit(lc.fall_lm, ev_zero_i, ev_prd_i);
    assign ctl_ld    = lc.ctl_glb  ? glb_hit : load_hit(lc.ctl_lm,  ev_zero_i, ev_prd_i);

    // Delay registers: index 0 = rising delay (address 0), 1 = falling delay (address 1).
    for (genvar i = 0; i < 2; i++) begin : g_dly
        db_shadow_reg #(.W(CNT_W)) u_sh (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (wr_en_i && wr_addr_i == 2'(i)),
            .wdata_i (wr_data_i[CNT_W-1:0]),
            .sh_en_i (dly_sh[i]),
            .load_i  (dly_ld[i]),
            .act_o   (dly_act[i])
        );
    end

    db_shadow_reg #(.W(CTRL_W)) u_ctl_sh (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_en_i && wr_addr_i == 2'd2),
        .wdata_i (wr_data_i[CTRL_W-1:0]),
        .sh_en_i (lc.ctl_sh),
        .load_i  (ctl_ld),
        .act_o   (ctl_raw)
    );

    assign ctl = ctrl_t'(ctl_raw);

    logic src_rise, src_fall, red_in, red_y, fed_y, chain_y;
    logic [CNT_W-1:0] chain_dly;

    assign src_rise  = ctl.src_rise ? aq_b_i : aq_a_i;
    assign src_fall  = ctl.src_fall ? aq_b_i : aq_a_i;
    assign red_in    = ctl.phase ? aq_a_i : src_rise;
    assign chain_dly = ctl.phase ? dly_act[0] : dly_act[1];

    db_edge_delay #(.W(CNT_W), .FALLING(1'b0)) u_red (
        .clk(clk), .rst_n(rst_n), .x_i(red_in), .dly_i(dly_act[0]), .y_o(red_y));

    db_edge_delay #(.W(CNT_W), .FALLING(1'b1)) u_fed (
        .clk(clk), .rst_n(rst_n), .x_i(src_fall), .dly_i(dly_act[1]), .y_o(fed_y));

    db_edge_delay #(.W(CNT_W), .FALLING(1'b1)) u_chain (
        .clk(clk), .rst_n(rst_n), .x_i(red_y), .dly_i(chain_dly), .y_o(chain_y));

    logic a_nxt, b_nxt;

    // Output routing: choose what drives each output slot.
    always_comb begin
        a_nxt = aq_a_i;
        b_nxt = aq_b_i;
        if (ctl.phase) begin
            b_nxt = chain_y;
        end else begin
            case (ctl.route)
                RT_SPLIT:  begin a_nxt = red_y;   b_nxt = fed_y;   end
                RT_BOTH_A: begin a_nxt = chain_y; b_nxt = aq_b_i;  end
                RT_BOTH_B: begin a_nxt = aq_a_i;  b_nxt = chain_y; end
                default:   begin a_nxt = aq_a_i;  b_nxt = aq_b_i;  end
            endcase
        end
    end

    logic glb_at_zero, glb_at_prd, bad_zero, bad_prd;

    assign glb_at_zero = (lc.glb_lm == LD_ZERO) || (lc.glb_lm == LD_EITHER);
    assign glb_at_prd  = (lc.glb_lm == LD_PRD)  || (lc.glb_lm == LD_EITHER);
    assign bad_zero = (lc.rise_glb && dly_act[0] == '0) || (lc.fall_glb && dly_act[1] == '0);
    assign bad_prd  = (lc.rise_glb && dly_act[0] == prd_i) || (lc.fall_glb && dly_act[1] == prd_i);

    // Output stage: polarity, output registers and the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_a_o   <= 1'b0;
            pwm_b_o   <= 1'b0;
            cfg_err_o <= 1'b0;
        end else begin
            pwm_a_o   <= a_nxt ^ ctl.pol_a;
            pwm_b_o   <= b_nxt ^ ctl.pol_b;
            cfg_err_o <= (glb_at_zero && bad_zero) || (glb_at_prd && bad_prd);
        end
    end

    // R2: bypass routing without inversion is a pure one-clock pipeline
    p_bypass_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.phase && ctl.route == RT_BYPASS && !ctl.pol_a && !ctl.pol_b)
        |=> (pwm_a_o == $past(aq_a_i) && pwm_b_o == $past(aq_b_i)));

    // R6: in phase mode output A follows input A with one clock latency
    p_phase_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.phase && !ctl.pol_a) |=> (pwm_a_o == $past(aq_a_i)));

endmodule

// File: tb/pwm_deadband_tb.sv
`timescale 1ns/1ps
module pwm_deadband_tb_top;

    localparam int CNT_W  = 12;
    localparam int DATA_W = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              aq_a = 1'b0, aq_b = 1'b0;
    logic              ev_zero = 1'b0, ev_prd = 1'b0, ev_glb = 1'b0;
    logic [CNT_W-1:0]  prd = '0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              pwm_a, pwm_b, cfg_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    pwm_deadband #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .aq_a_i(aq_a), .aq_b_i(aq_b),
        .ev_zero_i(ev_zero), .ev_prd_i(ev_prd), .ev_glb_i(ev_glb), .prd_i(prd),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .pwm_a_o(pwm_a), .pwm_b_o(pwm_b), .cfg_err_o(cfg_err));

    // req, ctrl, rise, fall, input a/b (bit i = step i), expected out a/b
    typedef struct packed {
        logic [7:0]  req;
        logic [7:0]  ctrl;
        logic [7:0]  rise;
        logic [7:0]  fall;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] ea;
        logic [15:0] eb;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{8'd3, 8'h00, 8'd2, 8'd3, 16'h03FC, 16'h0000, 16'h03F0, 16'h1FFC}, // R3 split
        '{8'd4, 8'h02, 8'd4, 8'd1, 16'h003C, 16'h0018, 16'h0000, 16'h0038}, // R4 swallow, fall from B
        '{8'd7, 8'h08, 8'd1, 8'd1, 16'h00F0, 16'h0000, 16'h00E0, 16'hFE0F}, // R7 invert B
        '{8'd5, 8'h10, 8'd2, 8'd3, 16'h01FE, 16'h0F00, 16'h0FF8, 16'h0F00}, // R5 both on A
        '{8'd8, 8'h21, 8'd1, 8'd2, 16'h0300, 16'h007C, 16'h0300, 16'h01F8}, // R8 both on B, rise from B
        '{8'd2, 8'h30, 8'd5, 8'd5, 16'h0A5A, 16'h3C3C, 16'h0A5A, 16'h3C3C}, // R2 bypass
        '{8'd6, 8'h40, 8'd3, 8'd7, 16'h007E, 16'h0000, 16'h007E, 16'h03F0}, // R6 phase shift
        '{8'd6, 8'h40, 8'd3, 8'd0, 16'h001C, 16'h0000, 16'h001C, 16'h0000}, // R6 short pulse
        '{8'd2, 8'h00, 8'd0, 8'd0, 16'h5555, 16'h0000, 16'h5555, 16'h5555}  // R2 zero delay
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wreg(input logic [1:0] addr, input logic [DATA_W-1:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_ev(input logic z, input logic p, input logic g);
        @(negedge clk);
        ev_zero = z; ev_prd = p; ev_glb = g;
        @(negedge clk);
        ev_zero = 1'b0; ev_prd = 1'b0; ev_glb = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            aq_a = 1'b0; aq_b = 1'b0;
        end
    endtask

    // Step index at which output A first goes high after input A rises (-1 if never).
    task automatic measure_rise(output int pos);
        pos = -1;
        idle(10);
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            aq_a = 1'b1;
            @(posedge clk); #1;
            if (pwm_a && pos < 0) pos = i;
        end
        idle(2);
    endtask

    initial begin
        int pos;
        logic [15:0] ga, gb;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 pwm_a", {31'd0, pwm_a}, 32'd0);
        check("R1 pwm_b", {31'd0, pwm_b}, 32'd0);
        check("R1 cfg_err", {31'd0, cfg_err}, 32'd0);
        measure_rise(pos);
        check("R1 rise delay zero", pos, 0);

        // Table of waveform vectors.
        for (int v = 0; v < NV; v++) begin
            idle(1);
            wreg(2'd0, DATA_W'(VEC[v].rise));
            wreg(2'd1, DATA_W'(VEC[v].fall));
            wreg(2'd2, DATA_W'(VEC[v].ctrl));
            idle(10);
            ga = '0; gb = '0;
            for (int i = 0; i < 16; i++) begin
                @(negedge clk);
                aq_a = VEC[v].a[i]; aq_b = VEC[v].b[i];
                @(posedge clk); #1;
                ga[i] = pwm_a; gb[i] = pwm_b;
            end
            check($sformatf("R%0d vec%0d out a", VEC[v].req, v), ga, VEC[v].ea);
            check($sformatf("R%0d vec%0d out b", VEC[v].req, v), gb, VEC[v].eb);
        end

        // R11: changing the delay mid-edge keeps the old value for that edge.
        wreg(2'd2, 14'h0);
        wreg(2'd0, 14'd4);
        idle(10);
        pos = -1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            aq_a = 1'b1;
            if (i == 1) begin wr_en = 1'b1; wr_addr = 2'd0; wr_data = '0; end
            else wr_en = 1'b0;
            @(posedge clk); #1;
            if (pwm_a && pos < 0) pos = i;
        end
        @(negedge clk); wr_en = 1'b0;
        check("R11 edge keeps old delay", pos, 4);
        measure_rise(pos);
        check("R11 next edge uses new delay", pos, 0);

        // R9: rising delay shadowed, load on counter period (code 01).
        wreg(2'd3, 14'h101);
        wreg(2'd0, 14'd3);
        measure_rise(pos);
        check("R9 shadow write held", pos, 0);
        pulse_ev(1'b1, 1'b0, 1'b0);
        measure_rise(pos);
        check("R9 zero event ignored in period mode", pos, 0);
        pulse_ev(1'b0, 1'b1, 1'b0);
        measure_rise(pos);
        check("R9 period event loads", pos, 3);

        // R9: either (code 10) loads on zero; frozen (code 11) never loads.
        wreg(2'd3, 14'h102);
        wreg(2'd0, 14'd6);
        pulse_ev(1'b1, 1'b0, 1'b0);
        measure_rise(pos);
        check("R9 either mode loads on zero", pos, 6);
        wreg(2'd3, 14'h103);
        wreg(2'd0, 14'd1);
        pulse_ev(1'b1, 1'b0, 1'b0);
        pulse_ev(1'b0, 1'b1, 1'b0);
        measure_rise(pos);
        check("R9 frozen mode never loads", pos, 6);

        // R10: global mode, global event = counter zero.
        wreg(2'd3, 14'h900);
        wreg(2'd0, 14'd5);
        pulse_ev(1'b1, 1'b0, 1'b0);
        measure_rise(pos);
        check("R10 local event ignored", pos, 6);
        pulse_ev(1'b0, 1'b1, 1'b1);
        measure_rise(pos);
        check("R10 global strobe on wrong event ignored", pos, 6);
        pulse_ev(1'b1, 1'b0, 1'b1);
        measure_rise(pos);
        check("R10 global strobe on zero loads", pos, 5);

        // R12: error flag for invalid delays under global load.
        wreg(2'd3, 14'h000);
        wreg(2'd0, 14'd0);
        wreg(2'd3, 14'h800);
        idle(2);
        check("R12 zero delay with global-at-zero", {31'd0, cfg_err}, 32'd1);
        wreg(2'd0, 14'd2);
        idle(2);
        check("R12 non-zero delay clears flag", {31'd0, cfg_err}, 32'd0);
        prd = 12'd2;
        wreg(2'd3, 14'h840);
        idle(2);
        check("R12 delay equal to period with global-at-period", {31'd0, cfg_err}, 32'd1);
        wreg(2'd3, 14'h040);
        idle(2);
        check("R12 not global gives no flag", {31'd0, cfg_err}, 32'd0);

        // R9: control word shadowed, load on counter zero; inversion shows the load.
        wreg(2'd3, 14'h400);
        wreg(2'd2, 14'h0C);
        idle(3);
        check("R9 control shadow held", {30'd0, pwm_a, pwm_b}, 32'd0);
        pulse_ev(1'b1, 1'b0, 1'b0);
        idle(2);
        check("R9 control loaded on zero (R7 inversion)", {30'd0, pwm_a, pwm_b}, 32'd3);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule